// File: doc/BRIEF.md
# Three-Wire Nibble Register Serial Master

This block drives a small serial peripheral whose registers are four bits wide. It uses three lines: a serial clock that idles high, a data output with its own output enable, and a data input from the shared pin. The caller drives the peripheral's chip enable itself, outside the block. Each request reads or writes one register. The request carries an address nibble and, for a write, a data nibble. The block builds command bytes from them. A command byte holds marker flags in its upper half and the address or data in its lower half.

A write sends two bytes. The first is the address tagged as an address phase. The second is the data nibble tagged as a data phase. A read sends one tagged address byte. It then releases the data line and clocks in one reply byte, most significant bit first. Only the reply's low nibble is returned. Bit spacing is a half period given in nanoseconds. It is turned into system clock cycles from the clock frequency parameter, so the serial timing does not depend on the system clock rate.

The request side is a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While a transfer is in flight, `req_ready` stays low and any asserted `req_valid` is ignored. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the caller must take `rsp_rdata` on that cycle.

Top module: `nib3w_master`

## Requirements
- R1: After reset, `ser_clk` is high, `ser_oe` is low, `busy` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A write request clocks out exactly 16 bits, most significant bit first. The first byte is 0x20 plus the address: bit 5 is the address marker and bits 3:0 are the address. The second byte is 0x10 plus the data nibble: bit 4 is the data marker and bits 3:0 are the data.
- R3: A read request clocks out one byte, 0x60 plus the address, where bit 6 is the read flag and bit 5 the address marker. It then clocks 8 more bits with `ser_oe` low, for 16 clock falls in total.
- R4: In a read, `ser_din` is sampled on the system cycle in which `ser_clk` falls, most significant bit first. `rsp_rdata` holds bits 3:0 of the assembled byte, and bits 7:4 have no effect on it.
- R5: `ser_clk` stays low for exactly HALF_CYC system cycles per bit. Before each fall it is high for at least HALF_CYC cycles. `ser_dout` changes only while `ser_clk` is high.
- R6: `ser_oe` rises one cycle after the first bit of an outgoing byte is placed on `ser_dout`. It is high at every clock fall of that byte and drops on the byte's final rising clock edge.
- R7: `req_ready` is the inverse of `busy`. A `req_valid` raised while busy starts nothing and changes nothing in the transfer in flight.
- R8: `rsp_valid` is high for exactly one cycle. That cycle is the one after the transfer's final rising `ser_clk` edge, and `busy` is low from that cycle on.
- R9: HALF_CYC equals the ceiling of CLK_HZ × HALF_NS / 10^9, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| busy | output | 1 | Transfer in flight |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read value, valid with rsp_valid after a read |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dout | output | 1 | Serial data output value |
| ser_oe | output | 1 | Serial data output enable |
| ser_din | input | 1 | Serial data input from the shared pin |

## Verification
Several results have fixed latencies:
- `busy` rises on the cycle after a request is accepted.
- Each low phase of `ser_clk` lasts exactly HALF_CYC cycles.
- `rsp_valid` appears exactly one system cycle after the sixteenth rising clock edge and is low again one cycle later.

The bench runs a small configuration with HALF_CYC of 3. It samples on falling system clock edges and counts cycles since the last observed serial clock rise, so each result is checked on the cycle it is due.

Writes are swept over every address and data pair, and reads over every address and reply nibble. The bench acts as the peripheral. It presents each reply bit after the preceding clock rise, which gives the block at least HALF_CYC cycles before it samples.

// File: rtl/nib3w_pkg.sv
package nib3w_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  // command byte flag positions (decoded by the peripheral)
  localparam int RD_POS = 6;
  localparam int AD_POS = 5;
  localparam int DT_POS = 4;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DATA} seq_t;
  typedef enum logic [1:0] {E_IDLE, E_PREP, E_HI, E_LO} eng_t;

  function automatic logic [BYTE_W-1:0] addr_cmd(input logic rd, input logic [NIB_W-1:0] a);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = a;
    b[AD_POS] = 1'b1;
    b[RD_POS] = rd;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] data_cmd(input logic [NIB_W-1:0] d);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = d;
    b[DT_POS] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/nib3w_timer.sv
module nib3w_timer #(
  parameter int HALF_CYC = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || expire)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nib3w_byte_io.sv
module nib3w_byte_io
  import nib3w_pkg::*;
#(
  parameter int HALF_CYC = 175
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rd,
  input  logic [BYTE_W-1:0] go_byte,
  input  logic              din,
  output logic              scl,
  output logic              dout,
  output logic              oe,
  output logic              done,
  output logic [NIB_W-1:0]  rx_nib
);
  localparam int BW = $clog2(BYTE_W);

  eng_t              st;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] rx;
  logic [BW-1:0]     bitn;
  logic              rd;
  logic              expire;

  nib3w_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(st == E_HI || st == E_LO),
    .expire(expire)
  );

  assign rx_nib = rx[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE; scl <= 1'b1; dout <= 1'b0; oe <= 1'b0; done <= 1'b0;
      tx <= '0; rx <= '0; bitn <= '0; rd <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          tx <= go_byte; dout <= go_byte[BYTE_W-1]; rd <= go_rd;
          bitn <= '0; st <= E_PREP;
        end
        E_PREP: begin
          oe <= !rd;
          st <= E_HI;
        end
        E_HI: if (expire) begin
          scl <= 1'b0;
          if (rd) rx <= {rx[BYTE_W-2:0], din};
          st <= E_LO;
        end
        E_LO: if (expire) begin
          scl <= 1'b1;
          if (bitn == BW'(BYTE_W - 1)) begin
            oe <= 1'b0; done <= 1'b1; st <= E_IDLE;
          end else begin
            bitn <= bitn + 1'b1;
            tx   <= {tx[BYTE_W-2:0], 1'b0};
            dout <= tx[BYTE_W-2];
            st   <= E_HI;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R6
  oe_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $stable(dout));
  // R5
  dout_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl |-> $stable(dout));
  // R6
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl && !oe && !$past(scl)));
endmodule

// File: rtl/nib3w_master.sv
module nib3w_master
  import nib3w_pkg::*;
#(
  parameter int CLK_HZ  = 250_000_000,
  parameter int HALF_NS = 700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             busy,
  output logic             rsp_valid,
  output logic [NIB_W-1:0] rsp_rdata,
  output logic             ser_clk,
  output logic             ser_dout,
  output logic             ser_oe,
  input  logic             ser_din
);
  localparam longint PROD   = longint'(CLK_HZ) * longint'(HALF_NS);
  localparam int     HC_RAW = int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int     HALF_CYC = (HC_RAW < 1) ? 1 : HC_RAW;

  seq_t              st;
  logic              lat_write;
  logic [NIB_W-1:0]  lat_addr;
  logic [NIB_W-1:0]  lat_wdata;
  logic              eng_go, eng_rd, eng_done;
  logic [BYTE_W-1:0] eng_byte;
  logic [NIB_W-1:0]  eng_rx;

  assign busy      = (st != S_IDLE);
  assign req_ready = !busy;

  always_comb begin
    eng_go   = 1'b0;
    eng_rd   = 1'b0;
    eng_byte = '0;
    if (st == S_IDLE) begin
      eng_go   = req_valid;
      eng_byte = addr_cmd(!req_write, req_addr);
    end else if (st == S_CMD) begin
      eng_go   = eng_done;
      eng_rd   = !lat_write;
      eng_byte = lat_write ? data_cmd(lat_wdata) : '0;
    end
  end

  nib3w_byte_io #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .go(eng_go), .go_rd(eng_rd), .go_byte(eng_byte),
    .din(ser_din),
    .scl(ser_clk), .dout(ser_dout), .oe(ser_oe),
    .done(eng_done), .rx_nib(eng_rx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lat_write <= 1'b0; lat_addr <= '0; lat_wdata <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          lat_write <= req_write; lat_addr <= req_addr; lat_wdata <= req_wdata;
          st <= S_CMD;
        end
        S_CMD: if (eng_done) st <= S_DATA;
        S_DATA: if (eng_done) begin
          rsp_valid <= 1'b1;
          if (!lat_write) rsp_rdata <= eng_rx;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_clk && !ser_oe));
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(lat_addr) && $stable(lat_write) && $stable(lat_wdata)));
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

// File: tb/nib3w_master_tb.sv
module nib3w_master_tb;
  localparam int CLK_HZ   = 250_000_000;
  localparam int HALF_NS  = 12;
  // R9: ceil(250e6 * 12e-9) = 3
  localparam int EXP_HALF = (CLK_HZ / 1_000_000 * HALF_NS + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0, req_wdata = '0;
  logic req_ready, busy, rsp_valid, ser_clk, ser_dout, ser_oe;
  logic [3:0] rsp_rdata;
  logic ser_din = 1'b0;

  always #2 clk = ~clk;

  nib3w_master #(.CLK_HZ(CLK_HZ), .HALF_NS(HALF_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_oe(ser_oe), .ser_din(ser_din)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // peripheral model
  int falls = 0, rises = 0, tim_err = 0, low_len = 0, high_len = 100, since_rise = 0;
  int rise_base = 0;
  logic prev_scl = 1'b1;
  logic [31:0] cap = '0, oem = '0;
  logic [7:0] reply = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (prev_scl && !ser_clk) begin
        falls++;
        cap = {cap[30:0], ser_dout};
        oem = {oem[30:0], ser_oe};
        if (high_len < EXP_HALF) tim_err++;
        low_len = 1;
      end else if (!prev_scl && !ser_clk) begin
        low_len++;
      end else if (!prev_scl && ser_clk) begin
        int n;
        rises++;
        since_rise = 0;
        if (low_len != EXP_HALF) tim_err++;
        high_len = 1;
        n = rises - rise_base;
        if (n >= 8 && n <= 15) ser_din = reply[15-n];
      end else begin
        high_len++;
      end
      prev_scl = ser_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [3:0] a, input logic [3:0] d,
                      input logic [7:0] rep, input bit poke);
    int f0, t0, w;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R7", "ready when idle", int'(req_ready), 1);
    reply = rep; rise_base = rises; f0 = falls; t0 = tim_err;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (5) begin
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
      end
      chk(req_ready == 1'b0, "R7", "ready while busy", int'(req_ready), 0);
      @(negedge clk); #1;
      req_valid = 1'b0;
    end
    w = 0;
    while (!rsp_valid && w < 2000) begin
      @(negedge clk); #1;
      w++;
    end
    chk(rsp_valid == 1'b1, "R8", "done seen", int'(rsp_valid), 1);
    chk(since_rise == 1, "R8", "done one cycle after last rise", since_rise, 1);
    chk(falls - f0 == 16, wr ? "R2" : "R3", "clock count", falls - f0, 16);
    chk(tim_err == t0, "R5", "phase timing errors", tim_err - t0, 0);
    if (wr) begin
      chk(cap[15:8] == 8'(32 + a), "R2", "address byte", int'(cap[15:8]), 32 + a);
      chk(cap[7:0] == 8'(16 + d), "R2", "data byte", int'(cap[7:0]), 16 + d);
      chk(oem[15:0] == 16'hFFFF, "R6", "oe at falls", int'(oem[15:0]), 16'hFFFF);
    end else begin
      chk(cap[15:8] == 8'(96 + a), "R3", "read command", int'(cap[15:8]), 96 + a);
      chk(oem[15:0] == 16'hFF00, "R3", "oe at falls", int'(oem[15:0]), 16'hFF00);
      chk(rsp_rdata == rep[3:0], "R4", "read nibble", int'(rsp_rdata), int'(rep[3:0]));
    end
    @(negedge clk); #1;
    chk(!rsp_valid && !busy && ser_clk && !ser_oe, "R8", "one-cycle pulse then idle",
        int'({rsp_valid, busy, ser_clk, ser_oe}), 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(ser_clk == 1'b1, "R1", "ser_clk reset", int'(ser_clk), 1);
    chk(ser_oe == 1'b0, "R1", "ser_oe reset", int'(ser_oe), 0);
    chk(!busy && req_ready && !rsp_valid, "R1", "idle flags",
        int'({busy, req_ready, rsp_valid}), 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 16; a++)
      for (int d = 0; d < 16; d++)
        xfer(1'b1, 4'(a), 4'(d), 8'h00, (d % 5) == 0);
    for (int a = 0; a < 16; a++)
      for (int v = 0; v < 16; v++)
        xfer(1'b0, 4'(a), 4'(15 - v), {4'(~v ^ a), 4'(v)}, (v % 7) == 3);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule